// File: doc/BRIEF.md
# Serial Identity Code Responder

This block gives a single-wire slave its 64-bit identity code and serves it one bit at a time. The code is built from a fixed 8-bit family code and a 48-bit serial number taken from a port. An 8-bit check byte is derived in hardware from those 56 bits. The bit engine computes it serially, one bit per cycle, as it leaves reset. The full code is then returned bit by bit on read requests, in a fixed least-significant-bit-first layout.

The same bit pointer also drives a compare mode. In this mode the bus side strobes in 64 received bits. The block raises a sticky mismatch flag on the first bit that differs from the stored code. A mismatch never halts the sequence; it is only reported. A start input begins a new sequence, and a clear input rewinds the pointer. Bits read past the end return 1, the released state of an open-drain line. On a shared bus, any other slave driving a 0 therefore wins the wired-AND.

Top module: `id_rom_responder`

## Requirements
- R1: Code bit k (k = 0..63) is family code bit k for k < 8 (default family 8'h0F), serial_i bit k-8 for 8 <= k < 56, and check byte bit k-56 for k >= 56; each field goes out least significant bit first.
- R2: The check byte uses polynomial x^8+x^5+x^4+1 in reflected form. It starts at 8'h00, and for each code bit 0..55 in order: feedback = crc[0] ^ bit, crc >>= 1, and if feedback is 1, crc ^= 8'h8C. ready_o is 0 out of reset, rises within 56 cycles and then stays 1.
- R3: A rd_req_i sampled at a clock edge while ready_o is 1 puts the bit at the pointer on bit_o, with bit_vld_o high, right after that edge, and advances the pointer by one.
- R4: Once 64 bits have been consumed, seq_end_o is 1, and every further read returns bit_o = 1 without moving the pointer.
- R5: rd_req_i and bit_in_stb_i have no effect while ready_o is 0: no bit_vld_o, and the pointer does not move.
- R6: A bit_in_stb_i compares bit_in_i with the code bit at the pointer and advances the pointer. mismatch_o sets on the first differing bit and stays set until start_i, even if later bits match.
- R7: A mismatch does not stop the sequence: the compare strobes keep advancing the pointer up to seq_end_o.
- R8: start_i rewinds the pointer to 0 and clears mismatch_o. clr_i rewinds the pointer to 0 at any time and leaves mismatch_o unchanged. A request or strobe in the same cycle as either one is ignored.
- R9: When rd_req_i and bit_in_stb_i arrive together, the read is served and the compare strobe is ignored.
- R10: While rst_ni is low, bit_vld_o, mismatch_o, seq_end_o and ready_o are 0 and bit_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; starts the check byte computation on release |
| serial_i | input | 48 | Serial number, held stable |
| clr_i | input | 1 | Rewind bit pointer |
| start_i | input | 1 | Begin new sequence: rewind pointer, clear mismatch |
| rd_req_i | input | 1 | Request next code bit |
| bit_in_stb_i | input | 1 | Compare strobe for bit_in_i |
| bit_in_i | input | 1 | Received bit to compare |
| ready_o | output | 1 | Check byte computed |
| bit_o | output | 1 | Returned code bit |
| bit_vld_o | output | 1 | bit_o answers the previous cycle's request |
| mismatch_o | output | 1 | Sticky compare mismatch |
| seq_end_o | output | 1 | All 64 bits consumed |

## Verification
Most faults in the internal state show up at the ports. A wrong check byte register corrupts only bits 56 to 63 of a full read, one cycle after the 57th request. A bad pointer shows up on the very next read as a bit from the wrong field. Shifted or reversed bits then spread over the whole read. A mismatch flag that clears or sets at the wrong time shows on mismatch_o in the cycle after the strobe that should or should not have set it. A pointer that fails to rewind or saturate shows up as a wrong seq_end_o or a 0 past the end.

// File: rtl/id_rom_pkg.sv
package id_rom_pkg;
  localparam int unsigned FAM_W  = 8;
  localparam int unsigned SER_W  = 48;
  localparam int unsigned CRC_W  = 8;
  localparam int unsigned BODY_W = FAM_W + SER_W;
  localparam int unsigned CODE_W = BODY_W + CRC_W;
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 8'h8C;

  function automatic logic [CRC_W-1:0] crc_step(logic [CRC_W-1:0] c, logic b);
    logic fb;
    fb = c[0] ^ b;
    crc_step = (c >> 1) ^ (fb ? CRC_POLY_REFL : '0);
  endfunction
endpackage

// File: rtl/id_crc8_serial.sv
module id_crc8_serial
  import id_rom_pkg::*;
#(
  parameter int unsigned BW = BODY_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BW-1:0]    body_i,
  output logic [CRC_W-1:0] crc_o,
  output logic             done_o
);
  localparam int unsigned CNT_W = $clog2(BW + 1);
  localparam int unsigned IDX_W = $clog2(BW);

  logic [CNT_W-1:0] cnt_q;
  logic [CRC_W-1:0] crc_q;
  logic             cur_bit;

  assign done_o  = (cnt_q == CNT_W'(BW));
  assign cur_bit = body_i[cnt_q[IDX_W-1:0]];
  assign crc_o   = crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      crc_q <= '0;
    end else if (!done_o) begin
      crc_q <= crc_step(crc_q, cur_bit);
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CRC_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (done_o && $stable(crc_o))); // R2
endmodule

// File: rtl/id_code_shifter.sv
module id_code_shifter
  import id_rom_pkg::*;
#(
  parameter int unsigned CW = CODE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] code_i,
  input  logic          ready_i,
  input  logic          clr_i,
  input  logic          start_i,
  input  logic          rd_req_i,
  input  logic          bit_in_stb_i,
  input  logic          bit_in_i,
  output logic          bit_o,
  output logic          bit_vld_o,
  output logic          mismatch_o,
  output logic          seq_end_o
);
  localparam int unsigned PTR_W = $clog2(CW + 1);
  localparam int unsigned IDX_W = $clog2(CW);

  logic [PTR_W-1:0] ptr_q;
  logic             bit_q, vld_q, mis_q;
  logic             rewind, rd_go, cmp_go, cur_bit;

  assign seq_end_o = (ptr_q == PTR_W'(CW));
  assign cur_bit   = seq_end_o ? 1'b1 : code_i[ptr_q[IDX_W-1:0]];
  assign rewind    = clr_i | start_i;
  assign rd_go     = ready_i & rd_req_i & ~rewind;
  assign cmp_go    = ready_i & bit_in_stb_i & ~rd_req_i & ~rewind & ~seq_end_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      bit_q <= 1'b1;
      vld_q <= 1'b0;
      mis_q <= 1'b0;
    end else begin
      vld_q <= rd_go;
      if (rd_go) bit_q <= cur_bit;
      if (rewind) ptr_q <= '0;
      else if ((rd_go | cmp_go) && !seq_end_o) ptr_q <= ptr_q + 1'b1;
      if (start_i) mis_q <= 1'b0;
      else if (cmp_go && (bit_in_i != cur_bit)) mis_q <= 1'b1;
    end
  end

  assign bit_o      = bit_q;
  assign bit_vld_o  = vld_q;
  assign mismatch_o = mis_q;

  AST_VLD_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_o |-> $past(rd_req_i && ready_i)); // R3
  AST_ONES_PAST_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_go && seq_end_o) |=> (bit_vld_o && bit_o && seq_end_o)); // R4
  AST_IDLE_WHEN_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |=> !bit_vld_o); // R5
  AST_MISMATCH_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mismatch_o && !start_i) |=> mismatch_o); // R6
  AST_START_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!mismatch_o && ptr_q == '0)); // R8
  AST_CLR_REWINDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !start_i) |=> (ptr_q == '0 && mismatch_o == $past(mismatch_o))); // R8
endmodule

// File: rtl/id_rom_responder.sv
module id_rom_responder
  import id_rom_pkg::*;
#(
  parameter logic [FAM_W-1:0] FAMILY_CODE = 8'h0F
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SER_W-1:0] serial_i,
  input  logic             clr_i,
  input  logic             start_i,
  input  logic             rd_req_i,
  input  logic             bit_in_stb_i,
  input  logic             bit_in_i,
  output logic             ready_o,
  output logic             bit_o,
  output logic             bit_vld_o,
  output logic             mismatch_o,
  output logic             seq_end_o
);
  logic [BODY_W-1:0] body;
  logic [CRC_W-1:0]  crc;
  logic [CODE_W-1:0] code;

  assign body = {serial_i, FAMILY_CODE};
  assign code = {crc, body};

  id_crc8_serial #(.BW(BODY_W)) i_crc (
    .clk_i, .rst_ni, .body_i(body), .crc_o(crc), .done_o(ready_o)
  );

  id_code_shifter #(.CW(CODE_W)) i_shift (
    .clk_i, .rst_ni, .code_i(code), .ready_i(ready_o),
    .clr_i, .start_i, .rd_req_i, .bit_in_stb_i, .bit_in_i,
    .bit_o, .bit_vld_o, .mismatch_o, .seq_end_o
  );

  AST_READY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o); // R2
endmodule

// File: tb/test_id_rom_responder.sv
module test_id_rom_responder;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [47:0] serial = 48'h1234_5678_9ABC;
  logic clr = 0, start = 0, rd_req = 0, stb = 0, bin = 0;
  logic ready, bout, bvld, mis, send;
  int   n_run = 0, n_fail = 0;
  logic [63:0] exp_code;

  always #5 clk = ~clk;

  id_rom_responder i_id_rom_responder (
    .clk_i(clk), .rst_ni, .serial_i(serial), .clr_i(clr), .start_i(start),
    .rd_req_i(rd_req), .bit_in_stb_i(stb), .bit_in_i(bin),
    .ready_o(ready), .bit_o(bout), .bit_vld_o(bvld), .mismatch_o(mis), .seq_end_o(send)
  );

  function automatic logic [63:0] build_code(logic [47:0] s);
    logic [55:0] b;
    logic [7:0]  c;
    b = {s, 8'h0F};
    c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      if (c[0] ^ b[i]) c = {1'b0, c[7:1]} ^ 8'h8C;
      else c = {1'b0, c[7:1]};
    end
    return {c, b};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;
    exp_code = build_code(serial);
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 60 && !ready; i++) @(negedge clk);
    chk(ready, "R2 ready", ready, 1);
  endtask

  task automatic pulse(ref logic s);
    s = 1; @(negedge clk); s = 0;
  endtask

  task automatic read_bit(output logic b, output logic v);
    rd_req = 1; @(negedge clk); rd_req = 0;
    b = bout; v = bvld;
  endtask

  task automatic cmp_bit(input logic b);
    bin = b; stb = 1; @(negedge clk); stb = 0;
  endtask

  task automatic t_reset_state();
    @(negedge clk); rst_ni = 0; @(negedge clk);
    chk({bvld, mis, send, ready, bout} == 5'b00001, "R10 reset outputs",
        {bvld, mis, send, ready, bout}, 5'b00001);
  endtask

  task automatic t_not_ready();
    logic b, v;
    do_reset();
    read_bit(b, v);
    chk(!v, "R5 no valid before ready", v, 0);
    cmp_bit(~exp_code[0]);
    chk(!mis, "R5 strobe ignored before ready", mis, 0);
    wait_ready();
    read_bit(b, v);
    chk(v && b == exp_code[0], "R5 pointer unmoved", {v, b}, {1'b1, exp_code[0]});
  endtask

  task automatic t_read_all(input string tag);
    logic b, v;
    logic [63:0] got;
    logic allv = 1;
    pulse(start);
    for (int i = 0; i < 64; i++) begin
      read_bit(b, v);
      got[i] = b;
      allv &= v;
    end
    chk(allv, {"R3 valid ", tag}, allv, 1);
    chk(got[7:0] == 8'h0F, {"R1 family ", tag}, got[7:0], 8'h0F);
    chk(got[55:8] == serial, {"R1 serial ", tag}, got[55:8], serial);
    chk(got[63:56] == exp_code[63:56], {"R2 check byte ", tag}, got[63:56], exp_code[63:56]);
    chk(send, {"R4 end ", tag}, send, 1);
    read_bit(b, v);
    chk(v && b, {"R4 ones past end ", tag}, {v, b}, 2'b11);
    read_bit(b, v);
    chk(v && b && send, {"R4 saturate ", tag}, {v, b, send}, 3'b111);
  endtask

  task automatic t_match_ok();
    pulse(start);
    for (int i = 0; i < 64; i++) cmp_bit(exp_code[i]);
    chk(!mis && send, "R6 clean match", {mis, send}, 2'b01);
  endtask

  task automatic t_match_bad(input int k);
    pulse(start);
    for (int i = 0; i < 64; i++) begin
      cmp_bit(i == k ? ~exp_code[i] : exp_code[i]);
      if (i == k - 1) chk(!mis, "R6 no flag before differing bit", mis, 0);
      if (i == k) chk(mis, "R6 flag on differing bit", mis, 1);
    end
    chk(mis, "R6 sticky after later matches", mis, 1);
    chk(send, "R7 sequence continues after mismatch", send, 1);
    pulse(start);
    chk(!mis && !send, "R8 start clears", {mis, send}, 2'b00);
  endtask

  task automatic t_clr();
    logic b, v;
    pulse(start);
    cmp_bit(~exp_code[0]);
    cmp_bit(exp_code[1]);
    pulse(clr);
    chk(mis, "R8 clr keeps mismatch", mis, 1);
    read_bit(b, v);
    chk(v && b == exp_code[0], "R8 clr rewinds", {v, b}, {1'b1, exp_code[0]});
    rd_req = 1; clr = 1; @(negedge clk); rd_req = 0; clr = 0;
    chk(!bvld, "R8 request with clr ignored", bvld, 0);
    read_bit(b, v);
    chk(b == exp_code[0], "R8 pointer at 0 after clr", b, exp_code[0]);
  endtask

  task automatic t_both();
    logic b, v;
    pulse(start);
    bin = ~exp_code[0]; stb = 1; rd_req = 1;
    @(negedge clk); stb = 0; rd_req = 0;
    chk(bvld && bout == exp_code[0] && !mis, "R9 read wins",
        {bvld, bout, mis}, {1'b1, exp_code[0], 1'b0});
    read_bit(b, v);
    chk(b == exp_code[1], "R9 single advance", b, exp_code[1]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_not_ready();
    t_read_all("serial A");
    t_match_ok();
    t_match_bad(20);
    t_match_bad(60);
    t_clr();
    t_both();
    serial = 48'hFEDC_0000_0F01;
    do_reset();
    wait_ready();
    t_read_all("serial B");
    t_match_bad(0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule